// File: doc/BRIEF.md
# BAR Access Router

This block sits behind the target side of a bus endpoint. Each incoming transaction arrives with a space flag (I/O or memory) and a 32-bit address. The block also receives the live base values of the base address registers and the two space-enable bits of the command register. It compares the address against every active base address register window and selects the winning window. The hit is then passed on as the function number of that window, which names the destination register bank, together with the offset of the address inside the window.

Window size, space type, function number and whether the window is active at all are elaboration parameters for each window. Two windows may carry the same function number, so one bank can be reached through an I/O window and through a memory window with identical offsets. A transaction that no enabled window claims is reported as a miss. The result appears on registered outputs one clock after the request.

Top module: `bar_access_router`

## Requirements
- R1: While reset is low and on the first cycle after it, `hit_o`, `miss_o`, `func_o` and `offset_o` are all zero.
- R2: A window with size parameter N hits when address bits [31:N] equal base bits [31:N]. The default windows are: window 0, I/O, N=7; window 1, memory, N=12; window 2, memory, N=14; window 3, memory, N=8.
- R3: `req_io_i`=1 marks an I/O-space access and 0 marks a memory-space access. An I/O window hits only I/O accesses, and a memory window hits only memory accesses.
- R4: When `io_en_i` is 0, I/O windows never hit. When `mem_en_i` is 0, memory windows never hit.
- R5: A window whose active bit is 0 (window 3 by default) never hits, even when its base matches the address.
- R6: A hit reports the function number of the winning window on `func_o`. The defaults are: windows 0 and 1 carry function 2, window 2 carries function 6, and window 3 carries function 5.
- R7: A hit reports address bits [N-1:0] of the winning window on `offset_o`, zero-extended to OFF_W (14) bits.
- R8: When a valid request hits no window, `miss_o` is 1 and `hit_o` is 0 on the following cycle.
- R9: When several windows hit, the lowest-numbered window decides `func_o` and `offset_o`.
- R10: Base bits below N, including the type and prefetch bits, have no effect on decoding.
- R11: Results appear one cycle after the request. After a cycle with `req_valid_i`=0, `hit_o` and `miss_o` are 0. Whenever `hit_o` is 0, `func_o` and `offset_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | A transaction is presented this cycle |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | ADDR_W | Transaction address |
| bar_base_i | input | NUM_BARS*ADDR_W | Base register values, window i in bits [i*ADDR_W +: ADDR_W] |
| io_en_i | input | 1 | Command-register I/O enable |
| mem_en_i | input | 1 | Command-register memory enable |
| hit_o | output | 1 | Registered: a window claimed the transaction |
| miss_o | output | 1 | Registered: valid transaction, no window claimed it |
| func_o | output | FUNC_W | Registered function number of the winning window |
| offset_o | output | OFF_W | Registered offset inside the winning window |

## Verification
The bench sweeps addresses from one window-width below each base to two widths above it. Every sweep runs in both spaces and under all four enable combinations, and the bases carry junk in their low bits. A compare at the wrong bit boundary would shift the window edges. A missing space or enable check would claim accesses it should drop. Masking the base with the wrong width would let the type and prefetch bits move a window. A second setup nests window 1 inside window 2 and places the inactive window 3 on its own region. A reversed priority would return function 6 with a 14-bit offset where function 2 is expected. Decoding the inactive window would turn its misses into hits. Idle cycles with a matching address check that no stale result leaks out.

// File: rtl/bar_router_pkg.sv
// Package: shared encodings and helpers for the BAR access router.
// Assumes window sizes below 64 bits.
package bar_router_pkg;

    localparam int SIZE_FIELD_W = 6;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    // Mask of the low nbits address bits (offset bits of a window).
    function automatic logic [63:0] window_mask(input int nbits);
        return (64'd1 << nbits) - 64'd1;
    endfunction

endpackage

// File: rtl/bar_window_match.sv
// Module: bar_window_match
// Decides whether one window claims the current transaction and
// produces the offset inside that window. Purely combinational.
// Assumes SIZE_BITS >= 4, so type and prefetch bits lie in the masked part.
module bar_window_match
    import bar_router_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 14,
    parameter int SIZE_BITS = 12,
    parameter bit IS_IO     = 1'b0,
    parameter bit ACTIVE    = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              req_io_i,
    input  logic              io_en_i,
    input  logic              mem_en_i,
    output logic              hit_o,
    output logic [OFF_W-1:0]  off_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(window_mask(SIZE_BITS));
    localparam space_e            BAR_SPACE = IS_IO ? SPACE_IO : SPACE_MEM;

    logic space_ok;
    logic enable_ok;
    logic base_eq;

    // Qualify the compare by space type, command enable and active bit.
    always_comb begin
        space_ok  = (space_e'(req_io_i) == BAR_SPACE);
        enable_ok = IS_IO ? io_en_i : mem_en_i;
        base_eq   = ((addr_i & ~LOW_MASK) == (base_i & ~LOW_MASK));
        hit_o     = ACTIVE && space_ok && enable_ok && base_eq;
        off_o     = OFF_W'(addr_i & LOW_MASK);
    end

endmodule

// File: rtl/bar_hit_priority.sv
// Module: bar_hit_priority
// Grants the lowest-numbered asserted hit. The output is one-hot or zero.
module bar_hit_priority #(
    parameter int NUM_BARS = 4
) (
    input  logic [NUM_BARS-1:0] hits_i,
    output logic [NUM_BARS-1:0] grant_o,
    output logic                any_o
);

    // Scan upward and keep only the first hit found.
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = 0; i < NUM_BARS; i++) begin
            if (hits_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bar_access_router.sv
// Module: bar_access_router (top)
// Routes a target transaction to a bank function number and a window offset.
// Windows are fixed by parameters. Bases and enables are live inputs.
// One registered stage. Synchronous active-low reset.
// Assumes OFF_W >= the largest window size and OFF_W <= ADDR_W.
module bar_access_router
    import bar_router_pkg::*;
#(
    parameter int                                NUM_BARS    = 4,
    parameter int                                ADDR_W      = 32,
    parameter int                                FUNC_W      = 3,
    parameter int                                OFF_W       = 14,
    parameter logic [NUM_BARS*SIZE_FIELD_W-1:0]  BAR_SIZE    = {6'd8, 6'd14, 6'd12, 6'd7},
    parameter logic [NUM_BARS*FUNC_W-1:0]        BAR_FUNC    = {3'd5, 3'd6, 3'd2, 3'd2},
    parameter logic [NUM_BARS-1:0]               BAR_IS_IO   = 4'b0001,
    parameter logic [NUM_BARS-1:0]               BAR_ACTIVE  = 4'b0111
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid_i,
    input  logic                       req_io_i,
    input  logic [ADDR_W-1:0]          req_addr_i,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_base_i,
    input  logic                       io_en_i,
    input  logic                       mem_en_i,
    output logic                       hit_o,
    output logic                       miss_o,
    output logic [FUNC_W-1:0]          func_o,
    output logic [OFF_W-1:0]           offset_o
);

    logic [NUM_BARS-1:0] hits;
    logic [NUM_BARS-1:0] grant;
    logic                any_hit;
    logic [OFF_W-1:0]    win_off [NUM_BARS];
    logic [FUNC_W-1:0]   sel_func;
    logic [OFF_W-1:0]    sel_off;

    // One matcher per window, configured from the parameter vectors.
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        bar_window_match #(
            .ADDR_W    (ADDR_W),
            .OFF_W     (OFF_W),
            .SIZE_BITS (int'(BAR_SIZE[g*SIZE_FIELD_W +: SIZE_FIELD_W])),
            .IS_IO     (BAR_IS_IO[g]),
            .ACTIVE    (BAR_ACTIVE[g])
        ) u_match (
            .addr_i   (req_addr_i),
            .base_i   (bar_base_i[g*ADDR_W +: ADDR_W]),
            .req_io_i (req_io_i),
            .io_en_i  (io_en_i),
            .mem_en_i (mem_en_i),
            .hit_o    (hits[g]),
            .off_o    (win_off[g])
        );
    end

    bar_hit_priority #(
        .NUM_BARS (NUM_BARS)
    ) u_prio (
        .hits_i  (hits),
        .grant_o (grant),
        .any_o   (any_hit)
    );

    // Mux function number and offset of the granted window (AND-OR).
    always_comb begin
        sel_func = '0;
        sel_off  = '0;
        for (int i = 0; i < NUM_BARS; i++) begin
            if (grant[i]) begin
                sel_func = sel_func | BAR_FUNC[i*FUNC_W +: FUNC_W];
                sel_off  = sel_off | win_off[i];
            end
        end
    end

    // Output stage: register the routing result, zero when not claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o    <= 1'b0;
            miss_o   <= 1'b0;
            func_o   <= '0;
            offset_o <= '0;
        end else begin
            hit_o    <= req_valid_i && any_hit;
            miss_o   <= req_valid_i && !any_hit;
            func_o   <= (req_valid_i && any_hit) ? sel_func : '0;
            offset_o <= (req_valid_i && any_hit) ? sel_off  : '0;
        end
    end

endmodule

// File: rtl/bar_access_router_chk.sv
// Module: bar_access_router_chk
// Checks the router's port behaviour over time. Attached by bind below.
module bar_access_router_chk #(
    parameter int FUNC_W = 3,
    parameter int OFF_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_io_i,
    input logic              io_en_i,
    input logic              mem_en_i,
    input logic              hit_o,
    input logic              miss_o,
    input logic [FUNC_W-1:0] func_o,
    input logic [OFF_W-1:0]  offset_o
);

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!hit_o && !miss_o)); // R11

    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_io_i && !io_en_i) |=> !hit_o); // R4

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_io_i && !mem_en_i) |=> !hit_o); // R4

    AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (func_o == '0 && offset_o == '0)); // R11

endmodule

bind bar_access_router bar_access_router_chk #(
    .FUNC_W (FUNC_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_io_i    (req_io_i),
    .io_en_i     (io_en_i),
    .mem_en_i    (mem_en_i),
    .hit_o       (hit_o),
    .miss_o      (miss_o),
    .func_o      (func_o),
    .offset_o    (offset_o)
);

// File: tb/sim_bar_access_router.sv
// Bench: sweeps addresses around each window in both spaces and under every
// enable setting. Expected results come from the requirement text.
module sim_bar_access_router;

    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid_i = 1'b0;
    logic            req_io_i = 1'b0;
    logic [31:0]     req_addr_i = '0;
    logic [NB*32-1:0] bar_base_i = '0;
    logic            io_en_i = 1'b0;
    logic            mem_en_i = 1'b0;
    logic            hit_o;
    logic            miss_o;
    logic [2:0]      func_o;
    logic [13:0]     offset_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Window table per R2, R3, R5 and R6.
    int    sz   [NB] = '{7, 12, 14, 8};
    int    fn   [NB] = '{2, 2, 6, 5};
    bit    isio [NB] = '{1'b1, 1'b0, 1'b0, 1'b0};
    bit    act  [NB] = '{1'b1, 1'b1, 1'b1, 1'b0};
    logic [31:0] base [NB];

    always #10 clk = ~clk;

    bar_access_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_io_i(req_io_i),
        .req_addr_i(req_addr_i), .bar_base_i(bar_base_i), .io_en_i(io_en_i),
        .mem_en_i(mem_en_i), .hit_o(hit_o), .miss_o(miss_o), .func_o(func_o),
        .offset_o(offset_o)
    );

    task automatic load_bases();
        for (int b = 0; b < NB; b++) bar_base_i[b*32 +: 32] = base[b];
    endtask

    task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act_v, exp_v);
        end
    endtask

    // Drive one transaction and check the registered result.
    task automatic run_req(input string tag, input bit vld, input bit io,
                           input logic [31:0] addr, input bit ioe, input bit meme);
        bit e_hit = 1'b0;
        int e_fn  = 0;
        int e_off = 0;
        @(negedge clk);
        req_valid_i = vld; req_io_i = io; req_addr_i = addr;
        io_en_i = ioe; mem_en_i = meme;
        if (vld) begin
            for (int b = 0; b < NB; b++) begin
                if (!e_hit && act[b] && (isio[b] == io) && (io ? ioe : meme)
                    && ((addr >> sz[b]) == (base[b] >> sz[b]))) begin
                    e_hit = 1'b1;
                    e_fn  = fn[b];
                    e_off = int'(addr & ((32'd1 << sz[b]) - 32'd1));
                end
            end
        end
        @(negedge clk);
        check(tag, {31'd0, hit_o}, {31'd0, e_hit});
        check(tag, {31'd0, miss_o}, {31'd0, vld && !e_hit});
        check(tag, {29'd0, func_o}, 32'(e_fn));
        check(tag, {18'd0, offset_o}, 32'(e_off));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        // Bases with junk low bits (type, prefetch) per R10.
        base[0] = 32'h0000_1081;
        base[1] = 32'h0004_0008;
        base[2] = 32'h0010_0000;
        base[3] = 32'h0020_0004;
        load_bases();
        repeat (3) @(negedge clk);
        check("R1 reset hit", {31'd0, hit_o}, 32'd0);
        check("R1 reset miss", {31'd0, miss_o}, 32'd0);
        check("R1 reset func", {29'd0, func_o}, 32'd0);
        check("R1 reset offset", {18'd0, offset_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset hit", {31'd0, hit_o}, 32'd0);

        // Disjoint windows, every space and enable combination.
        for (int b = 0; b < NB; b++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int en = 0; en < 4; en++) begin
                    for (int k = 0; k < 32; k++) begin
                        logic [31:0] win;
                        logic [31:0] a;
                        win = 32'd1 << sz[b];
                        a = (base[b] & ~(win - 32'd1)) - win
                            + 32'(k) * ((32'd3 * win) >> 5) + 32'(k % 4);
                        run_req("R2 R3 R4 R5 R6 R7 R8 R10", 1'b1, sp[0], a, en[0], en[1]);
                    end
                end
            end
        end

        // Nested windows: window 1 inside window 2, lowest index wins.
        base[1] = 32'h0010_1000;
        base[2] = 32'h0010_000C;
        base[3] = 32'h0030_0000;
        load_bases();
        for (int k = 0; k < 64; k++) begin
            run_req("R9 nested", 1'b1, 1'b0, 32'h0010_0000 + 32'(k) * 32'h100 + 32'(k), 1'b1, 1'b1);
        end
        // Inactive window 3 on its own region: always a miss.
        for (int k = 0; k < 16; k++) begin
            run_req("R5 inactive", 1'b1, 1'b0, 32'h0030_0000 + 32'(k) * 32'h11, 1'b1, 1'b1);
        end
        // Idle cycles with a matching address: nothing reported.
        for (int k = 0; k < 8; k++) begin
            run_req("R11 idle", 1'b0, 1'b0, 32'h0010_1000 + 32'(k), 1'b1, 1'b1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule